// File: doc/BRIEF.md
# Character I/O Flag and Interrupt Controller

This block sits beside the sequencer of a small accumulator machine. It holds an 8-bit input character register, an 8-bit output character register, an input-ready flag and an output-done flag. It also holds the interrupt-enable bit and the interrupt-pending bit. On the device side a keyboard-style source pushes characters in, and a printer-style sink takes characters out. Each side uses a ready/valid handshake gated by the matching flag.

On the processor side the sequencer raises `ioExec` at step 3 of an I/O instruction and passes six select bits taken from the instruction word. The block then returns single-cycle requests: load the low byte of the accumulator, or skip the next instruction. The block also watches the step counter. When interrupts are enabled and a flag is up, it raises the pending bit outside the three fetch steps. While that bit is high, the block drives the per-step register-transfer requests of a three-step interrupt cycle. That cycle saves the program counter at address 0 and resumes at address 1.

Top module: `ioIrqCtl`

## Requirements
- R1: After reset the input flag is 0 (`devInReady`=1), the output flag is 1 (`devOutValid`=0), and interrupt-enable and interrupt-pending are both 0.
- R2: A device push (`devInValid`=1) while the input flag is 0 loads `devInData` into the input register and sets the flag on the next edge. A push while the flag is 1 changes neither the register nor the flag.
- R3: With `ioExec`=1 and `ioSel[5]`=1 (character in), `acLoadReq` is 1 in that same cycle with `acLoadData` equal to the input register, and the input flag is 0 after the edge.
- R4: With `ioExec`=1 and `ioSel[4]`=1 (character out), the output register takes `acLow` and the output flag clears on the edge. A `devOutTake` while the flag is 0 sets the flag.
- R5: `skipReq` is 1 in the same cycle when `ioExec`=1 and either `ioSel[3]`=1 (skip on input) with the input flag 1, or `ioSel[2]`=1 (skip on output) with the output flag 1. Otherwise it is 0.
- R6: With `ioExec`=1, `ioSel[1]` sets interrupt-enable and `ioSel[0]` clears it. If both are 1, the enable ends at 0.
- R7: Interrupt-pending sets on an edge only when interrupt-enable is 1, at least one flag is 1, and `stepCnt` is 3 or more. At steps 0, 1 and 2 it stays 0.
- R8: While pending is 1, step 0 raises `arClrReq` and `trLoadPcReq`, step 1 raises `memWrTrReq` and `pcClrReq`, and step 2 raises `pcIncReq` and `scClrReq`. Each of these requests is 0 at every other time.
- R9: The edge at step 2 of the interrupt cycle clears both pending and interrupt-enable.
- R10: When a processor-side clear and a device-side set of the same flag fall on one edge, the flag ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| devInValid | input | 1 | Device offers a character |
| devInData | input | 8 | Offered character |
| devInReady | output | 1 | Input flag is clear; a push is accepted |
| devOutTake | input | 1 | Device consumes the output character |
| devOutValid | output | 1 | Output flag is clear; a character waits |
| devOutData | output | 8 | Output character register |
| ioExec | input | 1 | I/O instruction in its execute step |
| ioSel | input | 6 | Instruction select bits (in, out, skip-in, skip-out, enable, disable) |
| acLow | input | 8 | Low byte of the accumulator |
| stepCnt | input | 4 | Sequencer step counter |
| acLoadReq | output | 1 | Load accumulator low byte |
| acLoadData | output | 8 | Byte for the accumulator |
| skipReq | output | 1 | Increment program counter (skip) |
| ienOut | output | 1 | Interrupt-enable state |
| intActive | output | 1 | Interrupt-pending / interrupt cycle active |
| arClrReq | output | 1 | Clear address register |
| trLoadPcReq | output | 1 | Copy program counter to temporary register |
| memWrTrReq | output | 1 | Write temporary register to memory |
| pcClrReq | output | 1 | Clear program counter |
| pcIncReq | output | 1 | Increment program counter |
| scClrReq | output | 1 | Clear step counter |

## Verification
A stuck or wrongly set flag appears on the next clock through the device handshake outputs. It also appears at once in the same-cycle `skipReq` of a skip instruction. A bad interrupt-enable is visible directly on `ienOut`. It is also visible one edge after a step-3 cycle through `intActive`. A pending bit that fails to clear shows as interrupt-cycle requests repeating on the following step 0.

// File: rtl/ioIrqPkg.sv
package ioIrqPkg;
  typedef struct packed {
    logic inprLoad;
    logic fgiSet;
    logic fgiClr;
    logic outrLoad;
    logic fgoSet;
    logic fgoClr;
    logic ienSet;
    logic ienClr;
    logic pendSet;
    logic pendClr;
  } ioStrobes_t;
endpackage

// File: rtl/ioIrqCtrl.sv
module ioIrqCtrl
  import ioIrqPkg::*;
#(
  parameter int STEP_W      = 4,
  parameter int SEL_W       = 6,
  parameter int FETCH_STEPS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             devInValid,
  input  logic             devOutTake,
  input  logic             ioExec,
  input  logic [SEL_W-1:0] ioSel,
  input  logic [STEP_W-1:0] stepCnt,
  input  logic             fgi,
  input  logic             fgo,
  input  logic             ien,
  input  logic             pend,
  output ioStrobes_t       strb,
  output logic             acLoadReq,
  output logic             skipReq,
  output logic             arClrReq,
  output logic             trLoadPcReq,
  output logic             memWrTrReq,
  output logic             pcClrReq,
  output logic             pcIncReq,
  output logic             scClrReq
);
  localparam int SEL_IN   = SEL_W - 1;
  localparam int SEL_OUT  = SEL_W - 2;
  localparam int SEL_SKI  = SEL_W - 3;
  localparam int SEL_SKO  = SEL_W - 4;
  localparam int SEL_ION  = SEL_W - 5;
  localparam int SEL_IOF  = SEL_W - 6;
  localparam logic [STEP_W-1:0] STEP0 = STEP_W'(0);
  localparam logic [STEP_W-1:0] STEP1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] STEP2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] FETCH_END = STEP_W'(FETCH_STEPS);

  logic doIn, doOut, doIntEnd;

  always_comb begin
    doIn     = ioExec && ioSel[SEL_IN];
    doOut    = ioExec && ioSel[SEL_OUT];
    doIntEnd = pend && (stepCnt == STEP2);

    strb.inprLoad = devInValid && !fgi;
    strb.fgiSet   = devInValid && !fgi;
    strb.fgiClr   = doIn;
    strb.outrLoad = doOut;
    strb.fgoSet   = devOutTake && !fgo;
    strb.fgoClr   = doOut;
    strb.ienSet   = ioExec && ioSel[SEL_ION];
    strb.ienClr   = (ioExec && ioSel[SEL_IOF]) || doIntEnd;
    strb.pendSet  = !pend && ien && (fgi || fgo) && (stepCnt >= FETCH_END);
    strb.pendClr  = doIntEnd;

    acLoadReq = doIn;
    skipReq   = ioExec && ((ioSel[SEL_SKI] && fgi) || (ioSel[SEL_SKO] && fgo));

    arClrReq    = pend && (stepCnt == STEP0);
    trLoadPcReq = pend && (stepCnt == STEP0);
    memWrTrReq  = pend && (stepCnt == STEP1);
    pcClrReq    = pend && (stepCnt == STEP1);
    pcIncReq    = doIntEnd;
    scClrReq    = doIntEnd;
  end

  // R8
  int_step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arClrReq, memWrTrReq, pcIncReq}));

  // R5
  skip_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skipReq |-> (ioExec && (fgi || fgo)));

  // R8
  int_req_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arClrReq || memWrTrReq || pcIncReq) |-> pend);
endmodule

// File: rtl/ioIrqDp.sv
module ioIrqDp
  import ioIrqPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ioStrobes_t        strb,
  input  logic [DATA_W-1:0] devInData,
  input  logic [DATA_W-1:0] acLow,
  output logic [DATA_W-1:0] inpr,
  output logic [DATA_W-1:0] outr,
  output logic              fgi,
  output logic              fgo,
  output logic              ien,
  output logic              pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inpr <= '0;
      outr <= '0;
      fgi  <= 1'b0;
      fgo  <= 1'b1;
      ien  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (strb.inprLoad) inpr <= devInData;
      if (strb.outrLoad) outr <= acLow;
      // clears take priority over sets
      if (strb.fgiClr)      fgi <= 1'b0;
      else if (strb.fgiSet) fgi <= 1'b1;
      if (strb.fgoClr)      fgo <= 1'b0;
      else if (strb.fgoSet) fgo <= 1'b1;
      if (strb.ienClr)      ien <= 1'b0;
      else if (strb.ienSet) ien <= 1'b1;
      if (strb.pendClr)      pend <= 1'b0;
      else if (strb.pendSet) pend <= 1'b1;
    end
  end

  // R10
  fgi_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.fgiClr |=> !fgi);

  // R6
  ien_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ienClr |=> !ien);

  // R7
  pend_rise_needs_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(ien));

  // R4
  outr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.outrLoad |=> $stable(outr));

  // R2
  inpr_hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fgi |=> $stable(inpr));
endmodule

// File: rtl/ioIrqCtl.sv
module ioIrqCtl
  import ioIrqPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STEP_W      = 4,
  parameter int FETCH_STEPS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              devInValid,
  input  logic [DATA_W-1:0] devInData,
  output logic              devInReady,
  input  logic              devOutTake,
  output logic              devOutValid,
  output logic [DATA_W-1:0] devOutData,
  input  logic              ioExec,
  input  logic [5:0]        ioSel,
  input  logic [DATA_W-1:0] acLow,
  input  logic [STEP_W-1:0] stepCnt,
  output logic              acLoadReq,
  output logic [DATA_W-1:0] acLoadData,
  output logic              skipReq,
  output logic              ienOut,
  output logic              intActive,
  output logic              arClrReq,
  output logic              trLoadPcReq,
  output logic              memWrTrReq,
  output logic              pcClrReq,
  output logic              pcIncReq,
  output logic              scClrReq
);
  ioStrobes_t strb;
  logic fgi, fgo, ien, pend;
  logic [DATA_W-1:0] inpr, outr;

  ioIrqCtrl #(.STEP_W(STEP_W), .SEL_W(6), .FETCH_STEPS(FETCH_STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .devInValid(devInValid), .devOutTake(devOutTake),
    .ioExec(ioExec), .ioSel(ioSel), .stepCnt(stepCnt),
    .fgi(fgi), .fgo(fgo), .ien(ien), .pend(pend), .strb(strb),
    .acLoadReq(acLoadReq), .skipReq(skipReq),
    .arClrReq(arClrReq), .trLoadPcReq(trLoadPcReq), .memWrTrReq(memWrTrReq),
    .pcClrReq(pcClrReq), .pcIncReq(pcIncReq), .scClrReq(scClrReq)
  );

  ioIrqDp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .devInData(devInData), .acLow(acLow),
    .inpr(inpr), .outr(outr), .fgi(fgi), .fgo(fgo), .ien(ien), .pend(pend)
  );

  assign devInReady  = !fgi;
  assign devOutValid = !fgo;
  assign devOutData  = outr;
  assign acLoadData  = inpr;
  assign ienOut      = ien;
  assign intActive   = pend;
endmodule

// File: tb/ioIrqCtl_bench.sv
module ioIrqCtl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] S_IN = 6'b100000, S_OUT = 6'b010000, S_SKI = 6'b001000,
                         S_SKO = 6'b000100, S_ION = 6'b000010, S_IOF = 6'b000001;

  logic clk = 0, rst_n = 0;
  logic devInValid = 0, devOutTake = 0, ioExec = 0;
  logic [7:0] devInData = 0, acLow = 0;
  logic [5:0] ioSel = 0;
  logic [3:0] stepCnt = 0;
  logic devInReady, devOutValid, acLoadReq, skipReq, ienOut, intActive;
  logic [7:0] devOutData, acLoadData;
  logic arClrReq, trLoadPcReq, memWrTrReq, pcClrReq, pcIncReq, scClrReq;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ioIrqCtl u_ioIrqCtl (
    .clk(clk), .rst_n(rst_n), .devInValid(devInValid), .devInData(devInData),
    .devInReady(devInReady), .devOutTake(devOutTake), .devOutValid(devOutValid),
    .devOutData(devOutData), .ioExec(ioExec), .ioSel(ioSel), .acLow(acLow),
    .stepCnt(stepCnt), .acLoadReq(acLoadReq), .acLoadData(acLoadData),
    .skipReq(skipReq), .ienOut(ienOut), .intActive(intActive),
    .arClrReq(arClrReq), .trLoadPcReq(trLoadPcReq), .memWrTrReq(memWrTrReq),
    .pcClrReq(pcClrReq), .pcIncReq(pcIncReq), .scClrReq(scClrReq)
  );

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    devInValid = 0; devOutTake = 0; ioExec = 0; ioSel = 0;
  endtask

  // apply inputs just after a falling edge, leave settle time
  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  task automatic testReset();
    chk("R1 inReady", devInReady, 1);
    chk("R1 outValid", devOutValid, 0);
    chk("R1 ien", ienOut, 0);
    chk("R1 pend", intActive, 0);
  endtask

  task automatic testInput();
    devInValid = 1; devInData = 8'hA5; stepCnt = 4'd3; cyc();
    chk("R2 flag set", devInReady, 0);
    devInData = 8'h3C; cyc();
    idle();
    chk("R2 ignored when full", acLoadData, 8'hA5);
    ioExec = 1; ioSel = S_SKI; #1;
    chk("R5 SKI flag1", skipReq, 1);
    ioSel = S_IN; #1;
    chk("R3 acLoadReq", acLoadReq, 1);
    chk("R3 data", acLoadData, 8'hA5);
    cyc(); idle(); #1;
    chk("R3 flag cleared", devInReady, 1);
    chk("R3 pulse ends", acLoadReq, 0);
    ioExec = 1; ioSel = S_SKI; #1;
    chk("R5 SKI flag0", skipReq, 0);
    ioSel = S_SKO; #1;
    chk("R5 SKO flag1", skipReq, 1);
    cyc(); idle();
  endtask

  task automatic testOutput();
    acLow = 8'h5A; ioExec = 1; ioSel = S_OUT; cyc(); idle(); #1;
    chk("R4 outValid", devOutValid, 1);
    chk("R4 outData", devOutData, 8'h5A);
    ioExec = 1; ioSel = S_SKO; #1;
    chk("R5 SKO flag0", skipReq, 0);
    idle(); devOutTake = 1; cyc(); idle(); #1;
    chk("R4 taken", devOutValid, 0);
  endtask

  task automatic testEnable();
    ioExec = 1; ioSel = S_ION; stepCnt = 0; cyc(); idle(); #1;
    chk("R6 ion", ienOut, 1);
    ioExec = 1; ioSel = S_IOF; cyc(); idle(); #1;
    chk("R6 iof", ienOut, 0);
    ioExec = 1; ioSel = S_ION | S_IOF; cyc(); idle(); #1;
    chk("R6 both", ienOut, 0);
  endtask

  task automatic testInterrupt();
    // output flag is 1 here
    ioExec = 1; ioSel = S_ION; stepCnt = 4'd3; cyc(); idle(); #1;
    chk("R7 not yet (ien was 0)", intActive, 0);
    for (int s = 0; s < 3; s++) begin
      stepCnt = 4'(s); cyc();
      chk("R7 fetch window", intActive, 0);
    end
    stepCnt = 4'd4; cyc();
    chk("R7 set", intActive, 1);
    stepCnt = 0; #1;
    chk("R8 s0 ar", arClrReq, 1); chk("R8 s0 tr", trLoadPcReq, 1);
    chk("R8 s0 mem", memWrTrReq, 0); chk("R8 s0 inc", pcIncReq, 0);
    cyc(); stepCnt = 1; #1;
    chk("R8 s1 mem", memWrTrReq, 1); chk("R8 s1 pc", pcClrReq, 1);
    chk("R8 s1 ar", arClrReq, 0);
    cyc(); stepCnt = 2; #1;
    chk("R8 s2 inc", pcIncReq, 1); chk("R8 s2 sc", scClrReq, 1);
    chk("R8 s2 tr", trLoadPcReq, 0);
    cyc(); stepCnt = 0; #1;
    chk("R9 pend clr", intActive, 0);
    chk("R9 ien clr", ienOut, 0);
    chk("R8 none after", arClrReq, 0);
  endtask

  task automatic testPriority();
    ioExec = 1; ioSel = S_IN; devInValid = 1; devInData = 8'h77; cyc(); idle(); #1;
    chk("R10 fgi clear wins", devInReady, 1);
    acLow = 8'h11; ioExec = 1; ioSel = S_OUT; cyc(); idle(); #1;
    acLow = 8'h22; ioExec = 1; ioSel = S_OUT; devOutTake = 1; cyc(); idle(); #1;
    chk("R10 fgo clear wins", devOutValid, 1);
    chk("R10 outData", devOutData, 8'h22);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    testReset();
    testInput();
    testOutput();
    testEnable();
    testInterrupt();
    testPriority();
    finishRun();
  end
endmodule